// File: doc/BRIEF.md
# Region-Based Buffer Transfer Requester

This block decides when a host-bus master transfer should be requested for a small data buffer. The buffer is filled or drained byte by byte by a serial engine on one side and moved in bursts by the host bus on the other. Two byte pointers are kept, one for each side. The buffer is divided into equal regions, and the block compares the region each pointer lies in. Whenever the two pointers sit in different regions, at least one whole region can be moved. The block then issues a request for exactly one region, starting at the region that holds the host pointer.

A single mode input selects either two large regions (half the buffer each) or four small regions (a quarter each). Four small regions give the serial side up to three regions of slack while one region is moving on the host bus. Each request carries an offset, a byte count and a direction flag. All three are captured when the request is issued and stay fixed until the transfer finishes. The request is presented to a downstream controller, which accepts it and later reports that the transfer is done. At that point the host pointer moves past the region that was transferred.

Top module: `region_xfer_req`

## Requirements
- R1: After reset, both pointers are zero, the mode is two-region, and no request is valid.
- R2: With the effective mode at 0 (two-region), the region index is pointer bit AW-1, and every request has a byte count of 2^(AW-1) (32 with defaults).
- R3: With the effective mode at 1 (four-region), the region index is pointer bits AW-1:AW-2, and every request has a byte count of 2^(AW-2) (16 with defaults).
- R4: When no request is outstanding and the two pointers lie in different regions on a clock edge, `req_valid_o` rises after that edge.
- R5: The request offset is the host pointer rounded down to the base of its region.
- R6: `req_valid_o` stays high until it is sampled together with `req_accept_i`, and it is low on the following cycle.
- R7: Offset, count and direction are captured at issue and stay unchanged while the request is outstanding, whatever the serial pointer, the mode input or `dir_i` do. `req_dir_o` equals `dir_i` as sampled at issue.
- R8: `xfer_done_i` takes effect only after the request has been accepted. It then sets the host pointer to offset plus count, modulo 2^AW, and ends the outstanding state. At any other time it is ignored.
- R9: The mode input is copied into the effective mode only on edges where no request is outstanding and none is being issued. The new mode applies from the next cycle on.
- R10: No new request is issued between the issue of a request and its done.
- R11: Each `ser_adv_i` strobe advances the serial pointer by one byte, wrapping modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_mode_i | input | 1 | 1 selects four regions, 0 selects two |
| dir_i | input | 1 | Transfer direction, captured into the request |
| ser_adv_i | input | 1 | Serial side consumed or produced one byte |
| req_accept_i | input | 1 | Downstream controller takes the request |
| xfer_done_i | input | 1 | Host-bus transfer of the accepted request finished |
| req_valid_o | output | 1 | Request pending acceptance |
| req_off_o | output | AW | Start byte offset of the request |
| req_len_o | output | AW | Byte count of the request |
| req_dir_o | output | 1 | Direction of the request |

## Verification
The bench uses the default AW of 6, which gives a 64-byte buffer with 32-byte or 16-byte regions. With this size, both pointers wrap within a few dozen strobes, so requests that straddle the wrap are reached in both modes. Directed steps cover the first request in each mode, a done that arrives before acceptance, a mode change while a request is outstanding, and a host pointer that wraps back to zero. Random traffic that toggles the mode then compares every cycle against a bench-side model of the requirements.

// File: rtl/region_xfer_req.sv
module region_xfer_req #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          quad_mode_i,
  input  logic          dir_i,
  input  logic          ser_adv_i,
  input  logic          req_accept_i,
  input  logic          xfer_done_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_off_o,
  output logic [AW-1:0] req_len_o,
  output logic          req_dir_o
);
  localparam logic [AW-1:0] BIG   = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] SMALL = AW'(1) << (AW - 2);

  logic [AW-1:0] ser_ptr, host_ptr;
  logic          quad_q, busy;

  wire [AW-1:0] size   = quad_q ? SMALL : BIG;
  wire [AW-1:0] mask   = ~(size - AW'(1));
  wire          differ = ((ser_ptr ^ host_ptr) & mask) != '0;
  wire          issue  = !busy && differ;
  wire          finish = busy && !req_valid_o && xfer_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_ptr     <= '0;
      host_ptr    <= '0;
      quad_q      <= 1'b0;
      busy        <= 1'b0;
      req_valid_o <= 1'b0;
      req_off_o   <= '0;
      req_len_o   <= '0;
      req_dir_o   <= 1'b0;
    end else begin
      if (ser_adv_i) ser_ptr <= ser_ptr + AW'(1);
      if (!busy && !differ) quad_q <= quad_mode_i;
      if (issue) begin
        busy        <= 1'b1;
        req_valid_o <= 1'b1;
        req_off_o   <= host_ptr & mask;
        req_len_o   <= size;
        req_dir_o   <= dir_i;
      end else if (req_valid_o && req_accept_i) begin
        req_valid_o <= 1'b0;
      end
      if (finish) begin
        busy     <= 1'b0;
        host_ptr <= req_off_o + req_len_o;
      end
    end
  end
endmodule

// File: rtl/region_xfer_req_chk.sv
module region_xfer_req_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_accept_i,
  input logic          req_valid_o,
  input logic [AW-1:0] req_off_o,
  input logic [AW-1:0] req_len_o,
  input logic          req_dir_o
);
  localparam logic [AW-1:0] BIG   = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] SMALL = AW'(1) << (AW - 2);

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_accept_i |=> req_valid_o);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_accept_i |=> !req_valid_o);

  // R7
  req_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_accept_i |=>
      $stable(req_off_o) && $stable(req_len_o) && $stable(req_dir_o));

  // R2 R3
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_len_o == BIG || req_len_o == SMALL));

  // R5
  off_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> ((req_off_o & (req_len_o - AW'(1))) == '0));
endmodule

bind region_xfer_req region_xfer_req_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_accept_i (req_accept_i),
  .req_valid_o  (req_valid_o),
  .req_off_o    (req_off_o),
  .req_len_o    (req_len_o),
  .req_dir_o    (req_dir_o)
);

// File: tb/sim_region_xfer_req.sv
`timescale 1ns/1ps
module sim_region_xfer_req;
  localparam int AW = 6;
  localparam int NB = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic quad_mode_i = 1'b0, dir_i = 1'b0, ser_adv_i = 1'b0;
  logic req_accept_i = 1'b0, xfer_done_i = 1'b0;
  logic req_valid_o, req_dir_o;
  logic [AW-1:0] req_off_o, req_len_o;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  region_xfer_req #(.AW(AW)) u0 (.*);

  // bench model of the requirements
  int  m_ser, m_host, m_off, m_len;
  bit  m_quad, m_busy, m_valid, m_dir;

  function automatic int region_size(bit q);
    return q ? NB / 4 : NB / 2;
  endfunction

  function automatic int region_of(int p, bit q);
    return p / region_size(q);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ser = 0; m_host = 0; m_quad = 0; m_busy = 0;
      m_valid = 0; m_off = 0; m_len = 0; m_dir = 0;
    end else begin
      automatic bit differ = region_of(m_ser, m_quad) != region_of(m_host, m_quad);
      automatic bit issue  = !m_busy && differ;
      automatic bit finish = m_busy && !m_valid && xfer_done_i;
      automatic int sz     = region_size(m_quad);
      automatic bit nq     = (!m_busy && !differ) ? quad_mode_i : m_quad;
      if (ser_adv_i) m_ser = (m_ser + 1) % NB;
      if (issue) begin
        m_busy = 1; m_valid = 1; m_off = (m_host / sz) * sz; m_len = sz; m_dir = dir_i;
      end else if (m_valid && req_accept_i) m_valid = 0;
      if (finish) begin
        m_busy = 0; m_host = (m_off + m_len) % NB;
      end
      m_quad = nq;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic cmp_model();
    check("R4 R6 R10 valid", req_valid_o, m_valid);
    if (m_valid) begin
      check("R5 offset", req_off_o, m_off);
      check("R2 R3 count", req_len_o, m_len);
      check("R7 direction", req_dir_o, m_dir);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick();
    check("R1 reset valid", req_valid_o, 0);

    // two-region: 31 bytes keep serial pointer in region 0
    ser_adv_i = 1'b1;
    tick(31);
    check("R2 no request inside one region", req_valid_o, 0);
    tick();
    ser_adv_i = 1'b0;
    tick();
    check("R4 request raised", req_valid_o, 1);
    check("R5 offset", req_off_o, 0);
    check("R2 count 32", req_len_o, 32);

    // done before accept is ignored
    xfer_done_i = 1'b1; tick(); xfer_done_i = 1'b0;
    check("R8 early done ignored", req_valid_o, 1);
    check("R6 held", req_valid_o, 1);

    quad_mode_i = 1'b1;
    req_accept_i = 1'b1; tick(); req_accept_i = 1'b0;
    check("R6 dropped after accept", req_valid_o, 0);
    tick(2);
    check("R10 no new request before done", req_valid_o, 0);

    // done: host -> 32, same region as serial, mode then taken
    xfer_done_i = 1'b1; tick(); xfer_done_i = 1'b0;
    tick();
    check("R8 host advanced, no request", req_valid_o, 0);

    // four-region: serial to 48 (region 3), host 32 (region 2)
    dir_i = 1'b1;
    ser_adv_i = 1'b1; tick(16); ser_adv_i = 1'b0;
    tick();
    check("R9 R3 four-region request", req_valid_o, 1);
    check("R3 count 16", req_len_o, 16);
    check("R5 offset 32", req_off_o, 32);
    check("R7 direction captured", req_dir_o, 1);

    dir_i = 1'b0; quad_mode_i = 1'b0;
    ser_adv_i = 1'b1; tick(3); ser_adv_i = 1'b0;
    check("R7 count frozen", req_len_o, 16);
    check("R7 offset frozen", req_off_o, 32);
    check("R7 direction frozen", req_dir_o, 1);
    quad_mode_i = 1'b1;

    req_accept_i = 1'b1; tick(); req_accept_i = 1'b0;
    xfer_done_i = 1'b1; tick(); xfer_done_i = 1'b0;
    tick();
    check("R8 host 48, serial 51 same region", req_valid_o, 0);

    // serial wraps 51 -> 0
    ser_adv_i = 1'b1; tick(13); ser_adv_i = 1'b0;
    tick();
    check("R11 wrap gives request", req_valid_o, 1);
    check("R11 offset 48", req_off_o, 48);
    req_accept_i = 1'b1; tick(); req_accept_i = 1'b0;
    xfer_done_i = 1'b1; tick(); xfer_done_i = 1'b0;
    tick(2);
    check("R8 host wraps to 0", req_valid_o, 0);
    cmp_model();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      ser_adv_i    = ($urandom % 2) == 0;
      req_accept_i = ($urandom % 3) == 0;
      xfer_done_i  = ($urandom % 4) == 0;
      dir_i        = $urandom % 2;
      if (($urandom % 20) == 0) quad_mode_i = ~quad_mode_i;
      tick();
      cmp_model();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule